// File: doc/BRIEF.md
# Down-Counting Reload Timer Channel

A single timer channel for a peripheral subsystem. A 32-bit counter counts down at a rate derived from a peripheral clock enable (`tick_i`) divided by a selectable prescaler. When the counter steps down from zero it reloads from a reload register and sets a sticky underflow flag. The flag raises a level interrupt when the interrupt enable is set. The count pauses whenever the external run input (`start_i`) is low, and it resumes from the held value when the input returns high.

Software reaches the channel through a simple register port with single-cycle writes and combinational reads. The byte address is shifted right by two to form a word offset. Word 0 is the reload value, word 1 is the live counter, word 2 is the control register and word 3 is a capture storage word, which exists only when `HAS_CAPTURE` is set. The underflow flag can be cleared only by a control write that carries zero in bit 8. Software cannot set it.

Top module: `reload_timer_ch`

## Requirements
- R1: After reset the reload word and the counter word both read 0xFFFFFFFF, the control word reads 0 and `irq_o` is low.
- R2: Control bits [2:0] hold a divide code. Codes 0, 1, 2, 3 and 4 make the counter step once per 4, 16, 64, 256 and 1024 cycles in which both `tick_i` and `start_i` are high.
- R3: Divide codes 5, 6 and 7 stop the counter. It does not change while such a code is held.
- R4: A step taken while the counter is 0 loads the reload value and sets the underflow flag. Counting then continues periodically from the reload value.
- R5: While `start_i` is low, the counter and the prescaler phase both hold. Counting resumes from the held value and phase.
- R6: The underflow flag is sticky. A control write with bit 8 set to 1 leaves it unchanged. A control write with bit 8 set to 0 clears it.
- R7: A control read returns bits [7:0] as last written, bit 8 as the underflow flag, and zero in bits [31:9].
- R8: `irq_o` is high exactly when the underflow flag is set and control bit 5 (interrupt enable) is set.
- R9: Any control write restarts the prescaler phase. After the write, the first step needs a full divide period.
- R10: With `HAS_CAPTURE` set, word offset 3 stores and returns a written value. Without it, that word reads 0 and ignores writes.
- R11: A write to word offset 1 loads the counter directly. A write to word offset 0 changes only the reload value and leaves the live count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock enable that feeds the prescaler |
| start_i | input | 1 | Run input; counting happens only while high |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address; bits [3:2] form the word offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Underflow interrupt level |

## Verification
The bench sweeps the run length at the fastest divide cycle by cycle across several wraps. A design that is off by one, either in the terminal count or in the reload step, shows a count or flag value that drifts against the arithmetic expectation. Every legal divide code is checked after several wraps, so a ratio table that is wrong shows up as a wrong count. Three further checks cover a pause in the middle of a prescale period, a control write made after a partial period, and a clock enable running at half rate. A design that clears its prescaler on pause, keeps a stale phase, or counts cycles rather than enables gives an early or late step in one of these checks. The bench also tries to set the flag by writing 1, and checks that the reserved divide codes stop the counter.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam logic [1:0] OFS_RELOAD = 2'd0;
  localparam logic [1:0] OFS_COUNT  = 2'd1;
  localparam logic [1:0] OFS_CTRL   = 2'd2;
  localparam logic [1:0] OFS_CAPT   = 2'd3;

  localparam int CTRL_STORE_W = 8;  // bits [7:0] kept as written
  localparam int CTRL_IE_BIT  = 5;
  localparam int CTRL_UF_BIT  = 8;
  localparam int SEL_W        = 3;
endpackage

// File: rtl/timer_prescale.sv
module timer_prescale import timer_pkg::*; #(
  parameter int NUM_DIV = 5,
  localparam int PRE_W  = 2 * NUM_DIV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);
  logic [PRE_W-1:0] cnt_q, lim;
  logic             legal, adv;

  // ratio for code i is 4^(i+1)
  always_comb begin
    lim   = '0;
    legal = 1'b0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (sel_i == SEL_W'(i)) begin
        lim   = PRE_W'((1 << (2 * i + 2)) - 1);
        legal = 1'b1;
      end
    end
  end

  assign adv    = run_i & tick_i & legal & ~clr_i;
  assign step_o = adv & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv)    cnt_q <= step_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/timer_down.sv
module timer_down #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] reload_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              uf_o
);
  logic [DATA_W-1:0] cnt_q;

  assign uf_o  = step_i & ~load_i & (cnt_q == '0);
  assign cnt_o = cnt_q;

  // a direct load wins over a step in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '1;
    else if (load_i)  cnt_q <= load_val_i;
    else if (step_i)  cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end
endmodule

// File: rtl/reload_timer_ch.sv
module reload_timer_ch import timer_pkg::*; #(
  parameter int DATA_W      = 32,
  parameter int NUM_DIV     = 5,
  parameter bit HAS_CAPTURE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [1:0]              word;
  logic                    wr_reload, wr_count, wr_ctrl, wr_capt;
  logic [DATA_W-1:0]       reload_q, count, capt_rd;
  logic [CTRL_STORE_W-1:0] ctrl_q;
  logic                    uf_q, uf_set, step;

  assign word      = addr_i[3:2];
  assign wr_reload = wr_i & (word == OFS_RELOAD);
  assign wr_count  = wr_i & (word == OFS_COUNT);
  assign wr_ctrl   = wr_i & (word == OFS_CTRL);
  assign wr_capt   = wr_i & (word == OFS_CAPT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '1;
      ctrl_q   <= '0;
    end else begin
      if (wr_reload) reload_q <= wdata_i;
      if (wr_ctrl)   ctrl_q   <= wdata_i[CTRL_STORE_W-1:0];
    end
  end

  // sticky flag: hardware sets, software may only clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              uf_q <= 1'b0;
    else if (uf_set)                          uf_q <= 1'b1;
    else if (wr_ctrl && !wdata_i[CTRL_UF_BIT]) uf_q <= 1'b0;
  end

  timer_prescale #(.NUM_DIV(NUM_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (start_i),
    .tick_i (tick_i),
    .clr_i  (wr_ctrl),
    .sel_i  (ctrl_q[SEL_W-1:0]),
    .step_o (step)
  );

  timer_down #(.DATA_W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_count),
    .load_val_i (wdata_i),
    .step_i     (step),
    .reload_i   (reload_q),
    .cnt_o      (count),
    .uf_o       (uf_set)
  );

  generate
    if (HAS_CAPTURE) begin : g_capt
      logic [DATA_W-1:0] capt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      capt_q <= '0;
        else if (wr_capt) capt_q <= wdata_i;
      end
      assign capt_rd = capt_q;
    end else begin : g_no_capt
      assign capt_rd = '0;
    end
  endgenerate

  always_comb begin
    unique case (word)
      OFS_RELOAD: rdata_o = reload_q;
      OFS_COUNT:  rdata_o = count;
      OFS_CTRL:   rdata_o = DATA_W'({uf_q, ctrl_q});
      default:    rdata_o = capt_rd;
    endcase
  end

  assign irq_o = uf_q & ctrl_q[CTRL_IE_BIT];
endmodule

// File: rtl/reload_timer_ch_chk.sv
module reload_timer_ch_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_DIV = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              irq_o,
  input logic              step,
  input logic              wr_count,
  input logic              wr_ctrl,
  input logic              clr_bit,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] reload_q,
  input logic              uf_q,
  input logic [2:0]        sel
);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !wr_count) |=> $stable(count));

  assert_reserved_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sel) >= NUM_DIV) |-> !step);

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !wr_count && count != '0) |=> count == DATA_W'($past(count) - 1'b1));

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !wr_count && count == '0) |=> (count == $past(reload_q)) && uf_q);

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_q && !(wr_ctrl && !clr_bit)) |=> uf_q);

  assert_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> uf_q);

  assert_phase_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |-> !step);
endmodule

bind reload_timer_ch reload_timer_ch_chk #(.DATA_W(DATA_W), .NUM_DIV(NUM_DIV)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .irq_o    (irq_o),
  .step     (step),
  .wr_count (wr_count),
  .wr_ctrl  (wr_ctrl),
  .clr_bit  (wdata_i[8]),
  .count    (count),
  .reload_q (reload_q),
  .uf_q     (uf_q),
  .sel      (ctrl_q[2:0])
);

// File: tb/sim_reload_timer_ch.sv
`timescale 1ns/1ps
module sim_reload_timer_ch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1, start = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  reload_timer_ch u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wreg(input int w, input logic [31:0] d);
    addr = 4'(w << 2); wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input int w, output logic [31:0] d);
    addr = 4'(w << 2); #1; d = rdata;
  endtask

  // k clock edges with start high; half selects tick on every other edge
  task automatic run(input int k, input bit half);
    start = 1'b1;
    for (int i = 0; i < k; i++) begin
      tick = half ? (i % 2 == 0) : 1'b1;
      @(posedge clk); @(negedge clk);
    end
    start = 1'b0; tick = 1'b1;
  endtask

  function automatic logic [31:0] exp_cnt(input longint n, input longint r, input longint p);
    if (p <= n) return 32'(n - p);
    return 32'(r - ((p - n - 1) % (r + 1)));
  endfunction

  task automatic setup(input logic [31:0] r, input logic [31:0] n, input logic [31:0] c);
    wreg(0, r); wreg(1, n); wreg(2, c);
  endtask

  initial begin
    logic [31:0] v;
    int ratio;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rreg(0, v); check("R1 reload reset", v, 32'hFFFF_FFFF);
    rreg(1, v); check("R1 count reset", v, 32'hFFFF_FFFF);
    rreg(2, v); check("R1 ctrl reset", v, 32'h0);
    check("R1 irq reset", {31'd0, irq}, 32'd0);

    // sweep of run length at divide code 0
    for (int k = 0; k < 40; k++) begin
      setup(32'd3, 32'd2, 32'd0);
      run(k, 1'b0);
      rreg(1, v); check("R2/R4 sweep count", v, exp_cnt(2, 3, k / 4));
      rreg(2, v); check("R4/R7 sweep flag", v, {23'd0, (k / 4) > 2, 8'd0});
    end

    // every legal code across several wraps
    for (int c = 0; c < 5; c++) begin
      ratio = 4 << (2 * c);
      setup(32'd3, 32'd2, 32'(c));
      run(ratio * 5 + ratio / 2, 1'b0);
      rreg(1, v); check("R2 divide code", v, exp_cnt(2, 3, 5));
      rreg(2, v); check("R7 ctrl readback", v, 32'h100 | 32'(c));
    end

    // half-rate tick: 16 edges -> 8 ticks -> 2 steps
    setup(32'd50, 32'd10, 32'd0);
    run(16, 1'b1);
    rreg(1, v); check("R2 tick gating", v, 32'd8);

    // reserved codes stop counting
    for (int c = 5; c < 8; c++) begin
      setup(32'd7, 32'd5, 32'(c));
      run(300, 1'b0);
      rreg(1, v); check("R3 reserved code", v, 32'd5);
    end

    // pause keeps count and phase (code 1: /16)
    setup(32'd100, 32'd100, 32'd1);
    run(37, 1'b0);
    repeat (50) @(negedge clk);
    rreg(1, v); check("R5 paused count", v, 32'd98);
    run(27, 1'b0);
    rreg(1, v); check("R5 resumed count", v, 32'd96);

    // sticky flag and interrupt
    setup(32'd9, 32'd0, 32'd0);
    run(4, 1'b0);
    rreg(1, v); check("R4 reload on underflow", v, 32'd9);
    rreg(2, v); check("R4 flag set", v, 32'h100);
    check("R8 irq masked", {31'd0, irq}, 32'd0);
    wreg(2, 32'h120);
    rreg(2, v); check("R6 write one keeps flag", v, 32'h120);
    check("R8 irq raised", {31'd0, irq}, 32'd1);
    wreg(2, 32'h020);
    rreg(2, v); check("R6 write zero clears", v, 32'h020);
    check("R8 irq dropped", {31'd0, irq}, 32'd0);
    wreg(2, 32'h100);
    rreg(2, v); check("R6 software cannot set", v, 32'h0);
    wreg(2, 32'hFFFF_FFF8);
    rreg(2, v); check("R7 upper bits zero", v, 32'h0000_00F8);

    // control write restarts prescaler phase
    setup(32'd20, 32'd20, 32'd0);
    run(3, 1'b0);
    wreg(2, 32'd0);
    run(3, 1'b0);
    rreg(1, v); check("R9 phase restarted", v, 32'd20);
    run(1, 1'b0);
    rreg(1, v); check("R9 first step after full period", v, 32'd19);

    // capture storage and register offsets
    wreg(3, 32'hA5A5_1234);
    rreg(3, v); check("R10 capture store", v, 32'hA5A5_1234);
    wreg(1, 32'd77);
    wreg(0, 32'd5);
    rreg(1, v); check("R11 reload write leaves count", v, 32'd77);
    rreg(0, v); check("R11 reload readback", v, 32'd5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule